// File: doc/BRIEF.md
# Downstream Command Issue Register Interface

This block sits between a host CPU register bus and a peripheral link engine. Software fills two header extension words and a payload word. It then writes the first header word with its go bit set, and that write launches the command. The packed command goes out on a one-cycle strobe toward the link engine. The go bit then serves as the busy flag until the engine reports completion, and hardware clears it at that point.

Completion, a missing response and a link error are each recorded in an interrupt status register that software clears by writing ones. The link engine may already be running an alert-triggered status poll when software launches. In that case the strobe is held back until the poll ends, and a poll that got no response marks the no-response bit. A get-configuration command returns its reply by replacing the second header word. A write to the first header word while a command is in flight is dropped and raises a sticky overrun flag.

Top module: `dncmd_port`

## Requirements
- R1: After reset every register reads zero, and `busy`, `cmd_valid` and `int_status` are zero.
- R2: Word offsets are fixed as follows: 0 is header word 0, 1 is header word 1, 2 is header word 2, 3 is the payload word and 4 is the status register. Bits [7:6] of header word 0 and bits [31:8] of header word 2 read as zero, and unmapped offsets read zero.
- R3: A write to offset 0 with bit 3 set while idle sets `busy`. If no poll is active, `cmd_valid` is high for exactly the next cycle and carries these fields: kind = bits [2:0], device = bits [5:4], header data byte n at `cmd_hdata[8n+7:8n]` (bytes 0-2 from header word 0 bits [31:8], bytes 3-6 from header word 1, byte 7 from header word 2 bits [7:0]), and payload = payload word.
- R4: A write to offset 0 with bit 3 clear while idle stores the fields and launches nothing.
- R5: While `poll_active` is high a launched command is held. Its strobe appears in the first cycle in which `poll_active` is low.
- R6: `lnk_done` during a running command clears `busy` and sets status bit 0 on the next cycle. `lnk_no_resp` also sets bit 1 and `lnk_err` sets bit 2.
- R7: When a command of kind 1 (get-configuration) completes, header word 1 is replaced by `lnk_rdata`. All other kinds leave it unchanged.
- R8: `poll_done` together with `poll_no_resp` sets status bit 1.
- R9: Status bits stay set until software writes a one to them at offset 4. A new event in the same cycle wins over the clear.
- R10: A write to offset 0 while busy changes nothing and emits no strobe. It sets the sticky status bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| cmd_valid | output | 1 | Command strobe to link engine |
| cmd_kind | output | 3 | Command kind |
| cmd_dev | output | 2 | Peripheral select |
| cmd_hdata | output | 64 | Header data bytes 0-7 |
| cmd_payload | output | 32 | Payload word |
| lnk_done | input | 1 | Link engine finished the command |
| lnk_no_resp | input | 1 | Command saw no response |
| lnk_err | input | 1 | Command ended in error |
| lnk_rdata | input | 32 | Reply data for get-configuration |
| poll_active | input | 1 | Alert-triggered status poll in progress |
| poll_done | input | 1 | Status poll finished |
| poll_no_resp | input | 1 | Status poll got no response |
| busy | output | 1 | Command in flight |
| int_status | output | 4 | Status bits: 0 done, 1 no response, 2 error, 3 overrun |

## Verification
Several properties are checked on every cycle: a single strobe per launch, no strobe while idle, a queued command held while a poll runs, completion clearing busy and marking done, overrun flagging, and status bits staying set except under a write-one clear. The bench scenarios show the rest: the packing of fields into the strobe across several command kinds, the get-configuration reply overwriting header word 1, reserved bits reading zero, the exact release cycle after a poll, and the ignored write leaving header word 0 intact.

// File: rtl/dncmd_pkg.sv
package dncmd_pkg;

    localparam int WORD_W      = 32;
    localparam int ADDR_W      = 3;
    localparam int STAT_W      = 4;
    localparam int HDATA_BYTES = 8;
    localparam int HDATA_W     = 8 * HDATA_BYTES;
    localparam int KIND_W      = 3;
    localparam int DEV_W       = 2;

    localparam int ST_DONE   = 0;
    localparam int ST_NORESP = 1;
    localparam int ST_ERR    = 2;
    localparam int ST_OVR    = 3;

    typedef enum logic [KIND_W-1:0] {
        CK_SETCFG = 3'd0,
        CK_GETCFG = 3'd1,
        CK_INBRST = 3'd2,
        CK_PERIPH = 3'd4,
        CK_VWIRE  = 3'd5,
        CK_OOB    = 3'd6,
        CK_FLASH  = 3'd7
    } cmd_kind_e;

    typedef enum logic [ADDR_W-1:0] {
        RG_HDR0 = 3'd0,
        RG_HDR1 = 3'd1,
        RG_HDR2 = 3'd2,
        RG_DATA = 3'd3,
        RG_STAT = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic [23:0]       hbytes;
        logic [1:0]        rsvd;
        logic [DEV_W-1:0]  dev;
        logic              go;
        logic [KIND_W-1:0] kind;
    } hdr0_t;

    typedef struct packed {
        logic [KIND_W-1:0]  kind;
        logic [DEV_W-1:0]   dev;
        logic [HDATA_W-1:0] hdata;
        logic [WORD_W-1:0]  payload;
    } cmd_pkt_t;

    function automatic cmd_pkt_t pack_cmd(hdr0_t h0, logic [WORD_W-1:0] h1,
                                          logic [7:0] h2, logic [WORD_W-1:0] pay);
        cmd_pkt_t p;
        p.kind    = h0.kind;
        p.dev     = h0.dev;
        p.hdata   = {h2, h1, h0.hbytes};
        p.payload = pay;
        return p;
    endfunction

endpackage

// File: rtl/dncmd_hdr_regs.sv
module dncmd_hdr_regs
    import dncmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              fin,
    input  logic [WORD_W-1:0] reply,
    output hdr0_t             h0,
    output logic [WORD_W-1:0] h1,
    output logic [7:0]        h2,
    output logic [WORD_W-1:0] pay,
    output logic              launch,
    output logic              overrun
);
    logic wr_h0;

    assign wr_h0   = wr && (addr == RG_HDR0);
    assign launch  = wr_h0 && !h0.go && wdata[3];
    assign overrun = wr_h0 && h0.go;

    always_ff @(posedge clk) begin
        if (rst) begin
            h0  <= '0;
            h1  <= '0;
            h2  <= '0;
            pay <= '0;
        end else begin
            if (wr_h0 && !h0.go)
                h0 <= hdr0_t'({wdata[31:8], 2'b00, wdata[5:0]});
            if (wr && addr == RG_HDR1)
                h1 <= wdata;
            if (wr && addr == RG_HDR2)
                h2 <= wdata[7:0];
            if (wr && addr == RG_DATA)
                pay <= wdata;
            if (fin) begin
                h0.go <= 1'b0;
                if (h0.kind == CK_GETCFG)
                    h1 <= reply;
            end
        end
    end

endmodule

// File: rtl/dncmd_seq.sv
module dncmd_seq
    import dncmd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic launch,
    input  logic poll_active,
    input  logic lnk_done,
    output logic cmd_valid,
    output logic fin
);
    typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RUN} seq_e;
    seq_e state;

    assign cmd_valid = (state == S_WAIT) && !poll_active;
    assign fin       = (state == S_RUN) && lnk_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
        end else begin
            unique case (state)
                S_IDLE: if (launch)    state <= S_WAIT;
                S_WAIT: if (cmd_valid) state <= S_RUN;
                S_RUN:  if (fin)       state <= S_IDLE;
                default:               state <= S_IDLE;
            endcase
        end
    end

    p_single_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);
    p_launch_from_idle_r3: assert property (@(posedge clk) disable iff (rst)
        launch |-> state == S_IDLE);
    p_hold_during_poll_r5: assert property (@(posedge clk) disable iff (rst)
        (state == S_WAIT && poll_active) |=> state == S_WAIT);

endmodule

// File: rtl/dncmd_irq_stat.sv
module dncmd_irq_stat
    import dncmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] set_vec,
    input  logic              clr_wr,
    input  logic [STAT_W-1:0] clr_mask,
    output logic [STAT_W-1:0] stat
);
    logic [STAT_W-1:0] keep;

    assign keep = clr_wr ? ~clr_mask : '1;

    always_ff @(posedge clk) begin
        if (rst) stat <= '0;
        else     stat <= (stat & keep) | set_vec;
    end

    p_w1c_r9: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> ((stat & $past(clr_mask) & ~$past(set_vec)) == '0));
    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        !clr_wr |=> ((~stat & $past(stat)) == '0));

endmodule

// File: rtl/dncmd_port.sv
module dncmd_port
    import dncmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [WORD_W-1:0]  reg_wdata,
    output logic [WORD_W-1:0]  reg_rdata,
    output logic               cmd_valid,
    output logic [KIND_W-1:0]  cmd_kind,
    output logic [DEV_W-1:0]   cmd_dev,
    output logic [HDATA_W-1:0] cmd_hdata,
    output logic [WORD_W-1:0]  cmd_payload,
    input  logic               lnk_done,
    input  logic               lnk_no_resp,
    input  logic               lnk_err,
    input  logic [WORD_W-1:0]  lnk_rdata,
    input  logic               poll_active,
    input  logic               poll_done,
    input  logic               poll_no_resp,
    output logic               busy,
    output logic [STAT_W-1:0]  int_status
);
    hdr0_t             h0;
    logic [WORD_W-1:0] h1, pay;
    logic [7:0]        h2;
    logic              launch, overrun, fin;
    logic [STAT_W-1:0] set_vec;
    cmd_pkt_t          pkt;

    dncmd_hdr_regs u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .fin(fin), .reply(lnk_rdata), .h0(h0), .h1(h1), .h2(h2), .pay(pay),
        .launch(launch), .overrun(overrun)
    );

    dncmd_seq u_seq (
        .clk(clk), .rst(rst), .launch(launch), .poll_active(poll_active),
        .lnk_done(lnk_done), .cmd_valid(cmd_valid), .fin(fin)
    );

    always_comb begin
        set_vec            = '0;
        set_vec[ST_DONE]   = fin;
        set_vec[ST_NORESP] = (fin && lnk_no_resp) || (poll_done && poll_no_resp);
        set_vec[ST_ERR]    = fin && lnk_err;
        set_vec[ST_OVR]    = overrun;
    end

    dncmd_irq_stat u_stat (
        .clk(clk), .rst(rst), .set_vec(set_vec),
        .clr_wr(reg_wr && reg_addr == RG_STAT),
        .clr_mask(reg_wdata[STAT_W-1:0]), .stat(int_status)
    );

    assign pkt         = pack_cmd(h0, h1, h2, pay);
    assign cmd_kind    = pkt.kind;
    assign cmd_dev     = pkt.dev;
    assign cmd_hdata   = pkt.hdata;
    assign cmd_payload = pkt.payload;
    assign busy        = h0.go;

    always_comb begin
        case (reg_addr)
            RG_HDR0: reg_rdata = h0;
            RG_HDR1: reg_rdata = h1;
            RG_HDR2: reg_rdata = {{(WORD_W-8){1'b0}}, h2};
            RG_DATA: reg_rdata = pay;
            RG_STAT: reg_rdata = {{(WORD_W-STAT_W){1'b0}}, int_status};
            default: reg_rdata = '0;
        endcase
    end

    p_valid_when_busy_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> busy);
    p_fin_clears_busy_r6: assert property (@(posedge clk) disable iff (rst)
        fin |=> (!busy && int_status[ST_DONE]));
    p_overrun_flag_r10: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == RG_HDR0 && busy) |=> int_status[ST_OVR]);

endmodule

// File: tb/dncmd_port_test.sv
module dncmd_port_test;
    import dncmd_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [WORD_W-1:0] reg_wdata = '0;
    logic [WORD_W-1:0] reg_rdata;
    logic cmd_valid;
    logic [KIND_W-1:0] cmd_kind;
    logic [DEV_W-1:0] cmd_dev;
    logic [HDATA_W-1:0] cmd_hdata;
    logic [WORD_W-1:0] cmd_payload;
    logic lnk_done = 1'b0, lnk_no_resp = 1'b0, lnk_err = 1'b0;
    logic [WORD_W-1:0] lnk_rdata = '0;
    logic poll_active = 1'b0, poll_done = 1'b0, poll_no_resp = 1'b0;
    logic busy;
    logic [STAT_W-1:0] int_status;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    dncmd_port uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
        .cmd_kind(cmd_kind), .cmd_dev(cmd_dev), .cmd_hdata(cmd_hdata),
        .cmd_payload(cmd_payload), .lnk_done(lnk_done), .lnk_no_resp(lnk_no_resp),
        .lnk_err(lnk_err), .lnk_rdata(lnk_rdata), .poll_active(poll_active),
        .poll_done(poll_done), .poll_no_resp(poll_no_resp), .busy(busy),
        .int_status(int_status)
    );

    typedef struct packed {
        logic [2:0]  kind;
        logic [1:0]  dev;
        logic [23:0] hb;
        logic [31:0] h1;
        logic [7:0]  h2;
        logic [31:0] pay;
        logic        nr;
        logic        er;
        logic [31:0] reply;
        logic [3:0]  xstat;
        logic [31:0] xh1;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 2'd0, 24'h001000, 32'h0, 8'h00, 32'h0, 1'b0, 1'b0, 32'h0000_1234, 4'b0001, 32'h0000_1234},
        '{3'd0, 2'd1, 24'h000810, 32'hA5A5_0003, 8'h00, 32'h0, 1'b0, 1'b0, 32'hDEAD_BEEF, 4'b0001, 32'hA5A5_0003},
        '{3'd2, 2'd0, 24'h000000, 32'h0, 8'h00, 32'h0, 1'b1, 1'b0, 32'h0, 4'b0011, 32'h0},
        '{3'd5, 2'd2, 24'hC3B2A1, 32'h1122_3344, 8'h55, 32'h0000_0203, 1'b0, 1'b1, 32'hFFFF_FFFF, 4'b0101, 32'h1122_3344},
        '{3'd7, 2'd3, 24'h0F0E0D, 32'h8765_4321, 8'h99, 32'hCAFE_F00D, 1'b0, 1'b0, 32'h0, 4'b0001, 32'h8765_4321}
    };

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic finish_cmd(input logic nr, input logic er, input logic [31:0] rep);
        lnk_done = 1'b1; lnk_no_resp = nr; lnk_err = er; lnk_rdata = rep;
        @(negedge clk);
        lnk_done = 1'b0; lnk_no_resp = 1'b0; lnk_err = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 busy", busy, 0);
        chk("R1 cmd_valid", cmd_valid, 0);
        chk("R1 int_status", int_status, 0);
        for (int a = 0; a < 5; a++) begin
            rd(a[2:0], d);
            chk("R1 reg", d, 0);
        end
        rd(3'd7, d);
        chk("R2 unmapped", d, 0);

        // R2: reserved bits of header word 2
        wr(RG_HDR2, 32'hFFFF_FF5A);
        rd(RG_HDR2, d);
        chk("R2 hdr2 reserved", d, 32'h0000_005A);

        // R4 + R2: no launch, reserved bits of header word 0
        wr(RG_HDR0, 32'h1234_56C2);
        chk("R4 no strobe", cmd_valid, 0);
        chk("R4 not busy", busy, 0);
        @(negedge clk);
        chk("R4 no strobe later", cmd_valid, 0);
        rd(RG_HDR0, d);
        chk("R2 hdr0 reserved", d, 32'h1234_5602);

        // Vector table: R3, R6, R7, R9
        for (int i = 0; i < NV; i++) begin
            wr(RG_HDR1, VECS[i].h1);
            wr(RG_HDR2, {24'h0, VECS[i].h2});
            wr(RG_DATA, VECS[i].pay);
            wr(RG_HDR0, {VECS[i].hb, 2'b00, VECS[i].dev, 1'b1, VECS[i].kind});
            chk("R3 strobe", cmd_valid, 1);
            chk("R3 busy", busy, 1);
            chk("R3 kind", cmd_kind, VECS[i].kind);
            chk("R3 dev", cmd_dev, VECS[i].dev);
            chk("R3 hdata", cmd_hdata, {VECS[i].h2, VECS[i].h1, VECS[i].hb});
            chk("R3 payload", cmd_payload, VECS[i].pay);
            @(negedge clk);
            chk("R3 single strobe", cmd_valid, 0);
            chk("R3 still busy", busy, 1);
            finish_cmd(VECS[i].nr, VECS[i].er, VECS[i].reply);
            chk("R6 busy cleared", busy, 0);
            rd(RG_STAT, d);
            chk("R6 status", d, {28'h0, VECS[i].xstat});
            rd(RG_HDR1, d);
            chk("R7 hdr1", d, VECS[i].xh1);
            wr(RG_STAT, 32'h0000_000F);
            rd(RG_STAT, d);
            chk("R9 cleared", d, 0);
        end

        // R9: partial clear keeps other bits
        wr(RG_HDR0, 32'h0000_0008);
        @(negedge clk);
        finish_cmd(1'b1, 1'b1, 32'h0);
        wr(RG_STAT, 32'h0000_0002);
        rd(RG_STAT, d);
        chk("R9 partial clear", d, 32'h0000_0005);
        wr(RG_STAT, 32'h0000_000F);

        // R5: launch queued behind active poll
        @(negedge clk);
        poll_active = 1'b1;
        wr(RG_HDR0, 32'h0000_000C);
        chk("R5 held", cmd_valid, 0);
        chk("R5 busy", busy, 1);
        repeat (3) @(negedge clk);
        chk("R5 still held", cmd_valid, 0);
        poll_active = 1'b0; poll_done = 1'b1; poll_no_resp = 1'b1;
        #1 chk("R5 released", cmd_valid, 1);
        chk("R5 kind", cmd_kind, 3'd4);
        @(negedge clk);
        poll_done = 1'b0; poll_no_resp = 1'b0;
        chk("R5 one strobe", cmd_valid, 0);
        rd(RG_STAT, d);
        chk("R8 poll no-response", d, 32'h0000_0002);

        // R10: write while busy is ignored and flagged
        wr(RG_HDR0, 32'hFFFF_FF0D);
        chk("R10 no strobe", cmd_valid, 0);
        rd(RG_HDR0, d);
        chk("R10 hdr0 kept", d, 32'h0000_000C);
        rd(RG_STAT, d);
        chk("R10 overrun", d, 32'h0000_000A);
        finish_cmd(1'b0, 1'b0, 32'h0);
        rd(RG_STAT, d);
        chk("R10 sticky", d, 32'h0000_000B);
        chk("R6 busy after", busy, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule